// File: doc/BRIEF.md
# ATA Task-File Window Decoder

This block sits between the host side of a removable-storage card and its ATA register core. A host access arrives as an offset into the card's common-memory or I/O space. The block translates that offset into an ATA task-file register index. A two-bit window mode selects one of four translations: a memory-mapped window, a contiguous 16-byte I/O block, the legacy primary I/O ranges, or the legacy secondary I/O ranges.

The block sends data-port and task-file accesses to the ATA core as a single-cycle strobe. The strobe carries an index, a direction and write data. The block answers three card-local registers itself:

- the alternate-status readback;
- the device-control register, which can also issue a soft-reset request;
- a computed device-address byte.

When the card is in power-down, a task-file write produces a wake pulse. Offsets that land on no register are dropped, and reads of them return zero.

Window mode encoding: 0 = memory, 1 = contiguous I/O, 2 = primary I/O, 3 = secondary I/O. "Mapped index" below means the translated offset, before dispatch.

Top module: `ata_window_decoder`

## Requirements
- R1: In mode 0, any offset from 0x400 to 0x7FF maps to index 0. Every other offset is used unchanged as the mapped index.
- R2: In mode 1, the mapped index is the low four bits of the offset.
- R3: In mode 2, offsets 0x1F0..0x1FF map to offset minus 0x1F0, and offsets 0x3F0..0x3FF map to offset minus 0x3E8. Any other offset is used unchanged.
- R4: In mode 3, offsets 0x170..0x17F map to offset minus 0x170, and offsets 0x370..0x37F map to offset minus 0x368. Any other offset is used unchanged.
- R5: Mapped indices 0x0 and 0x8 reach the core as register 0 (16-bit data). Indices 0x1..0x7 reach the core as the same register number. Index 0xD reaches the core as register 1, in both directions.
- R6: A core access is a strobe one clock after the accepted request, with index, direction and write data valid in that cycle. Every read answers on `rd_valid` in that same cycle. For core reads, `rd_data` carries `core_rdata`.
- R7: A read of mapped index 0xE returns `drv_status` when `drv_present` is 1, and 0 when it is 0. No core strobe is issued.
- R8: A write to mapped index 0xE loads the low byte of the write data into `devctl`, with no core strobe. `devctl` is 0 after reset and changes on no other access.
- R9: `soft_rst_req` pulses for one cycle, together with the `devctl` update, when bit 2 of a write to index 0xE is 1.
- R10: A read of mapped index 0xF returns 0xC2 OR ((inverted `drv_select` bits 3:0) shifted left by 2), with no core strobe.
- R11: A write to core register 1..7 coming from mapped indices 0x1..0x7, while `pwrdn` is 1, raises `wake_pulse` in the strobe cycle. Data-port writes, index-0xD writes, and writes while `pwrdn` is 0 never raise it.
- R12: Mapped indices 0x9..0xC or above 0xF, and writes to index 0xF, issue no strobe and change no state. Reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Host access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_ofs | input | 11 | Offset within the card window |
| acc_wdata | input | 16 | Host write data |
| win_mode | input | 2 | Window mode (0 mem, 1 contiguous, 2 primary, 3 secondary) |
| pwrdn | input | 1 | Card is in power-down |
| drv_present | input | 1 | A drive is attached |
| drv_status | input | 8 | Active drive status byte |
| drv_select | input | 8 | Drive/head select register value |
| core_rdata | input | 16 | Read data returned by the ATA core during a strobe |
| tf_strobe | output | 1 | Single-cycle core access |
| tf_write | output | 1 | Direction of the core access |
| tf_index | output | 3 | Core task-file register |
| tf_wdata | output | 16 | Write data to the core |
| rd_valid | output | 1 | Host read answer valid |
| rd_data | output | 16 | Host read answer |
| devctl | output | 8 | Device-control register |
| soft_rst_req | output | 1 | Soft-reset request pulse |
| wake_pulse | output | 1 | Leave power-down and set ready |

## Verification
The hardest cases to reach are the folded control windows of the legacy modes. Offsets such as 0x3F6 or 0x37F translate onto the card-local indices 0xE and 0xF, or just past them. Reaching them needs the right mode paired with offsets at both ends of each 16-byte block. The stimulus walks every mode through window edges and through unmatched offsets. It holds `pwrdn` high across data-port, index-0xD and plain task-file writes, so the wake rule is separated from the writes that must not trigger it. A behavioural model predicts every output on every clock.

// File: rtl/ata_win_pkg.sv
// Package: shared types for the ATA task-file window decoder.
// Assumes a 4-bit task-file index space; anything above 0xF is unmapped.
package ata_win_pkg;

    typedef enum logic [1:0] {
        WIN_MEM       = 2'd0,
        WIN_CONTIG    = 2'd1,
        WIN_PRIMARY   = 2'd2,
        WIN_SECONDARY = 2'd3
    } win_mode_e;

    typedef enum logic [2:0] {
        K_NONE    = 3'd0,
        K_DATA    = 3'd1,
        K_FWD     = 3'd2,
        K_ERRFEAT = 3'd3,
        K_ALTSTAT = 3'd4,
        K_DEVADDR = 3'd5
    } reg_kind_e;

    localparam int IDX_DATA_HI = 8;
    localparam int IDX_ERRFEAT = 13;
    localparam int IDX_CTL     = 14;
    localparam int IDX_DEVADDR = 15;
    localparam int DEVADDR_FIXED = 'hC2;

endpackage

// File: rtl/ata_win_map.sv
// Module: translates a window offset into a mapped register index per mode.
// Assumes OFS_W >= 11 so that the memory and legacy windows fit.
module ata_win_map
    import ata_win_pkg::*;
#(
    parameter int OFS_W    = 11,
    parameter int MEM_BASE = 'h400,
    parameter int MEM_SPAN = 'h400,
    parameter int PRI_CMD  = 'h1F0,
    parameter int PRI_CTL  = 'h3F0,
    parameter int SEC_CMD  = 'h170,
    parameter int SEC_CTL  = 'h370
) (
    input  win_mode_e        mode,
    input  logic [OFS_W-1:0] ofs,
    output logic [OFS_W-1:0] mapped
);
    // The control blocks fold onto indices 8..F, so the subtrahend is base-8.
    localparam logic [OFS_W-1:0] MEM_LO  = OFS_W'(MEM_BASE);
    localparam logic [OFS_W-1:0] MEM_HI  = OFS_W'(MEM_BASE + MEM_SPAN - 1);
    localparam logic [OFS_W-1:0] PRI_CMD_V = OFS_W'(PRI_CMD);
    localparam logic [OFS_W-1:0] PRI_CTL_V = OFS_W'(PRI_CTL);
    localparam logic [OFS_W-1:0] SEC_CMD_V = OFS_W'(SEC_CMD);
    localparam logic [OFS_W-1:0] SEC_CTL_V = OFS_W'(SEC_CTL);
    localparam logic [OFS_W-1:0] PRI_FOLD  = OFS_W'(PRI_CTL - 8);
    localparam logic [OFS_W-1:0] SEC_FOLD  = OFS_W'(SEC_CTL - 8);

    logic [OFS_W-5:0] blk;
    assign blk = ofs[OFS_W-1:4];

    // Purpose: apply the window translation selected by the mode field.
    always_comb begin
        mapped = ofs;
        unique case (mode)
            WIN_MEM: begin
                if (ofs >= MEM_LO && ofs <= MEM_HI) mapped = '0;
            end
            WIN_CONTIG: begin
                mapped = {{(OFS_W-4){1'b0}}, ofs[3:0]};
            end
            WIN_PRIMARY: begin
                if (blk == PRI_CMD_V[OFS_W-1:4])      mapped = ofs - PRI_CMD_V;
                else if (blk == PRI_CTL_V[OFS_W-1:4]) mapped = ofs - PRI_FOLD;
            end
            WIN_SECONDARY: begin
                if (blk == SEC_CMD_V[OFS_W-1:4])      mapped = ofs - SEC_CMD_V;
                else if (blk == SEC_CTL_V[OFS_W-1:4]) mapped = ofs - SEC_FOLD;
            end
            default: mapped = ofs;
        endcase
    end

endmodule

// File: rtl/ata_win_dispatch.sv
// Module: classifies a mapped index into a register kind and a core index.
// Assumes indices above 0xF hit no register.
module ata_win_dispatch
    import ata_win_pkg::*;
#(
    parameter int OFS_W = 11
) (
    input  logic [OFS_W-1:0] mapped,
    input  logic             is_write,
    output reg_kind_e        kind,
    output logic [2:0]       core_idx
);
    logic in_range;
    assign in_range = (mapped[OFS_W-1:4] == '0);

    // Purpose: pick the destination of the access from the 4-bit index.
    always_comb begin
        kind     = K_NONE;
        core_idx = 3'd0;
        if (in_range) begin
            if (mapped[3:0] == 4'd0 || 32'(mapped[3:0]) == IDX_DATA_HI) begin
                kind = K_DATA;
            end else if (mapped[3] == 1'b0) begin
                kind     = K_FWD;
                core_idx = mapped[2:0];
            end else if (32'(mapped[3:0]) == IDX_ERRFEAT) begin
                kind     = K_ERRFEAT;
                core_idx = 3'd1;
            end else if (32'(mapped[3:0]) == IDX_CTL) begin
                kind = K_ALTSTAT;
            end else if (32'(mapped[3:0]) == IDX_DEVADDR && !is_write) begin
                kind = K_DEVADDR;
            end
        end
    end

endmodule

// File: rtl/ata_window_decoder.sv
// Module: top of the task-file window decoder. Registers the core strobe,
// answers card-local registers and holds the device-control byte.
// Assumes core_rdata is valid combinationally during tf_strobe.
module ata_window_decoder
    import ata_win_pkg::*;
#(
    parameter int OFS_W  = 11,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [OFS_W-1:0]  acc_ofs,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [1:0]        win_mode,
    input  logic              pwrdn,
    input  logic              drv_present,
    input  logic [7:0]        drv_status,
    input  logic [7:0]        drv_select,
    input  logic [DATA_W-1:0] core_rdata,
    output logic              tf_strobe,
    output logic              tf_write,
    output logic [2:0]        tf_index,
    output logic [DATA_W-1:0] tf_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [7:0]        devctl,
    output logic              soft_rst_req,
    output logic              wake_pulse
);
    localparam int SRST_BIT = 2;

    logic [OFS_W-1:0]  mapped;
    reg_kind_e         kind;
    logic [2:0]        core_idx;
    logic              to_core;
    logic              ctl_wr;
    logic [7:0]        local_val;
    logic [DATA_W-1:0] local_rd;
    logic              rd_from_core;

    ata_win_map #(.OFS_W(OFS_W)) u_map (
        .mode   (win_mode_e'(win_mode)),
        .ofs    (acc_ofs),
        .mapped (mapped)
    );

    ata_win_dispatch #(.OFS_W(OFS_W)) u_disp (
        .mapped   (mapped),
        .is_write (acc_write),
        .kind     (kind),
        .core_idx (core_idx)
    );

    assign to_core = acc_valid && (kind == K_DATA || kind == K_FWD || kind == K_ERRFEAT);
    assign ctl_wr  = acc_valid && acc_write && kind == K_ALTSTAT;

    // Purpose: form the byte a card-local register read returns.
    always_comb begin
        local_val = 8'h00;
        if (kind == K_ALTSTAT)      local_val = drv_present ? drv_status : 8'h00;
        else if (kind == K_DEVADDR) local_val = 8'(DEVADDR_FIXED) | {2'b00, ~drv_select[3:0], 2'b00};
    end

    // Purpose: register the core strobe and its index, direction and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tf_strobe <= 1'b0;
            tf_write  <= 1'b0;
            tf_index  <= 3'd0;
            tf_wdata  <= '0;
        end else begin
            tf_strobe <= to_core;
            tf_write  <= to_core && acc_write;
            tf_index  <= to_core ? core_idx : 3'd0;
            tf_wdata  <= (to_core && acc_write) ? acc_wdata : '0;
        end
    end

    // Purpose: register the host read answer source and local value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid     <= 1'b0;
            rd_from_core <= 1'b0;
            local_rd     <= '0;
        end else begin
            rd_valid     <= acc_valid && !acc_write;
            rd_from_core <= to_core && !acc_write;
            local_rd     <= (acc_valid && !acc_write) ? DATA_W'(local_val) : '0;
        end
    end

    assign rd_data = rd_from_core ? core_rdata : local_rd;

    // Purpose: hold device control and raise the reset and wake pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            devctl       <= 8'h00;
            soft_rst_req <= 1'b0;
            wake_pulse   <= 1'b0;
        end else begin
            if (ctl_wr) devctl <= acc_wdata[7:0];
            soft_rst_req <= ctl_wr && acc_wdata[SRST_BIT];
            wake_pulse   <= acc_valid && acc_write && kind == K_FWD && pwrdn;
        end
    end

    // R6: a core strobe always follows an accepted request.
    a_r6_strobe_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        tf_strobe |-> $past(acc_valid));

    // R8: device control moves only after a host write.
    a_r8_devctl_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(devctl) |-> $past(acc_valid && acc_write));

    // R9: a reset request comes with the reset bit held in device control.
    a_r9_srst_has_ctl_bit: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_req |-> devctl[SRST_BIT]);

    // R11: a wake pulse rides on a core write to a non-data register.
    a_r11_wake_on_tf_write: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> (tf_strobe && tf_write && tf_index != 3'd0));

    // R7: local reads never strobe the core.
    a_r7_local_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && (kind == K_ALTSTAT || kind == K_DEVADDR)) |=> !tf_strobe);

endmodule

// File: tb/ata_window_decoder_tb_top.sv
// Bench: behavioural model predicts every output each clock; compared at negedge.
module ata_window_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [10:0] acc_ofs = '0;
    logic [15:0] acc_wdata = '0;
    logic [1:0]  win_mode = '0;
    logic        pwrdn = 1'b0, drv_present = 1'b0;
    logic [7:0]  drv_status = '0, drv_select = '0;
    logic [15:0] core_rdata;
    logic        tf_strobe, tf_write, rd_valid, soft_rst_req, wake_pulse;
    logic [2:0]  tf_index;
    logic [15:0] tf_wdata, rd_data;
    logic [7:0]  devctl;

    always #10 clk = ~clk;

    // Core model: read data tags the register it was read from.
    assign core_rdata = 16'hA500 | {13'd0, tf_index};

    ata_window_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_ofs(acc_ofs), .acc_wdata(acc_wdata), .win_mode(win_mode),
        .pwrdn(pwrdn), .drv_present(drv_present), .drv_status(drv_status),
        .drv_select(drv_select), .core_rdata(core_rdata),
        .tf_strobe(tf_strobe), .tf_write(tf_write), .tf_index(tf_index),
        .tf_wdata(tf_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .devctl(devctl), .soft_rst_req(soft_rst_req), .wake_pulse(wake_pulse)
    );

    int    n_vec = 0, n_bad = 0;
    bit    done = 0;
    int    e_stb = 0, e_wr = 0, e_idx = 0, e_wd = 0, e_rdv = 0, e_rd = 0;
    int    e_srst = 0, e_wake = 0, e_ctl = 0;
    string e_tag = "R8";

    task automatic chk(string what, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", e_tag, what, act, exp);
        end
    endtask

    task automatic compare();
        chk("tf_strobe", int'(tf_strobe), e_stb);
        chk("tf_write", int'(tf_write), e_wr);
        if (e_stb != 0) chk("tf_index", int'(tf_index), e_idx);
        if (e_stb != 0 && e_wr != 0) chk("tf_wdata", int'(tf_wdata), e_wd);
        chk("rd_valid", int'(rd_valid), e_rdv);
        if (e_rdv != 0) chk("rd_data", int'(rd_data), e_rd);
        chk("soft_rst_req", int'(soft_rst_req), e_srst);
        chk("wake_pulse", int'(wake_pulse), e_wake);
        chk("devctl", int'(devctl), e_ctl);
    endtask

    function automatic int map_ofs(int md, int o);
        if (md == 0) return (o >= 'h400 && o <= 'h7FF) ? 0 : o;
        if (md == 1) return o % 16;
        if (md == 2) begin
            if (o >= 'h1F0 && o <= 'h1FF) return o - 'h1F0;
            if (o >= 'h3F0 && o <= 'h3FF) return o - 'h3E8;
            return o;
        end
        if (o >= 'h170 && o <= 'h17F) return o - 'h170;
        if (o >= 'h370 && o <= 'h37F) return o - 'h368;
        return o;
    endfunction

    task automatic idle(string tag);
        @(negedge clk);
        compare();
        acc_valid = 1'b0;
        e_stb = 0; e_wr = 0; e_rdv = 0; e_srst = 0; e_wake = 0;
        e_tag = tag;
    endtask

    task automatic acc(bit w, int md, int o, int wd, string tag);
        int m;
        @(negedge clk);
        compare();
        acc_valid = 1'b1; acc_write = w; win_mode = 2'(md);
        acc_ofs = 11'(o); acc_wdata = 16'(wd);
        e_tag = tag;
        e_stb = 0; e_wr = 0; e_idx = 0; e_wd = 0; e_srst = 0; e_wake = 0;
        e_rdv = w ? 0 : 1; e_rd = 0;
        m = map_ofs(md, o);
        if (m == 0 || m == 8 || (m >= 1 && m <= 7) || m == 13) begin
            e_stb = 1; e_wr = w ? 1 : 0; e_wd = wd;
            e_idx = (m == 13) ? 1 : (m == 8 ? 0 : m);
            e_rd = 'hA500 | e_idx;
            if (w && m >= 1 && m <= 7 && pwrdn) e_wake = 1;
        end else if (m == 14) begin
            if (w) begin
                e_ctl = wd % 256;
                e_srst = ((wd / 4) % 2 == 1) ? 1 : 0;
            end else begin
                e_rd = drv_present ? int'(drv_status) : 0;
            end
        end else if (m == 15 && !w) begin
            e_rd = 'hC2 | ((15 - (drv_select % 16)) * 4);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle("R8");                        // reset state
        idle("R6");
        drv_present = 1'b1; drv_status = 8'h50; drv_select = 8'hA0;
        acc(0, 0, 'h400, 0, "R1");         // memory window low edge -> data
        acc(1, 0, 'h7FF, 'h1234, "R1");    // memory window high edge -> data
        acc(0, 0, 'h003, 0, "R1");         // pass-through register 3
        acc(0, 0, 'h00E, 0, "R7");         // alternate status, drive present
        acc(0, 0, 'h012, 0, "R12");        // beyond 0xF -> nothing
        acc(0, 1, 'h7F5, 0, "R2");         // low nibble 5
        acc(1, 1, 'h3A8, 'hBEEF, "R5");    // index 8 -> data port
        acc(1, 1, 'h12D, 'h0033, "R5");    // index D -> register 1
        acc(0, 1, 'h00F, 0, "R10");        // device address, select low nibble 0
        acc(1, 1, 'h00F, 'h00FF, "R12");   // write to 0xF dropped
        acc(0, 1, 'h00A, 0, "R12");        // index A reads 0
        acc(0, 2, 'h1F7, 0, "R3");
        drv_present = 1'b0;
        acc(0, 2, 'h3F6, 0, "R7");         // no drive -> 0
        drv_select = 8'h1B;
        acc(0, 2, 'h3F7, 0, "R10");        // 0xD2
        acc(1, 2, 'h1F0, 'h0101, "R3");
        acc(0, 2, 'h3F0, 0, "R3");         // folds onto 8 -> data
        acc(0, 2, 'h3F9, 0, "R3");         // 0x11 -> nothing
        acc(0, 2, 'h100, 0, "R12");        // unmatched offset
        pwrdn = 1'b1;
        acc(1, 3, 'h172, 'h0007, "R11");   // wake on task-file write
        acc(1, 3, 'h170, 'h0008, "R11");   // data port: no wake
        acc(1, 3, 'h17D, 'h0009, "R11");   // index D: no wake
        acc(1, 3, 'h376, 'h0004, "R9");    // soft reset request
        acc(1, 3, 'h376, 'h00A2, "R8");    // control load, no reset
        acc(0, 3, 'h37F, 0, "R4");         // 0x17 -> nothing
        acc(0, 3, 'h17F, 0, "R4");         // device address in secondary
        acc(0, 3, 'h1F5, 0, "R4");         // unmatched in secondary
        pwrdn = 1'b0;
        acc(1, 3, 'h173, 'h00C3, "R11");   // no power-down -> no wake
        acc(0, 3, 'h376, 0, "R6");         // back-to-back traffic
        idle("R6");
        idle("R6");
        idle("R6");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule